// File: doc/BRIEF.md
# Long-Descriptor Page Table Walker

This block translates a 32-bit virtual address into a 40-bit physical address by walking three-level long-format translation tables held in memory. A translation request carries the virtual address, a 32-bit control word and two 64-bit table base words. The walker first picks which base word governs the address. The choice depends on how many top address bits are all zero or all one. It then works out the first descriptor address and may start the walk at level 2 when the selected region is small.

At each level it issues one 64-bit read on a request/response memory port. It decodes the returned descriptor as invalid, table, block or page. Attribute bits from table descriptors are gathered into a sticky set, which is folded into the attribute vector of the final block or page descriptor. The result has these parts:

- the physical address
- the page size as a power of two
- the merged attributes
- the level where the walk ended
- a fault flag

The result is presented with a one-cycle completion pulse and then held until the next request completes. Permission checks, caching of translations, and shareability or cacheability handling are left to the surrounding logic.

Top module: `ltw_walker`

## Requirements
- R1: Region choice follows this priority. Let the low region size be control bits [2:0] and the high region size be control bits [18:16].
  1. If the low size is nonzero and that many top address bits are all zero, base word 0 is used.
  2. Otherwise, if the high size is nonzero and that many top bits are all one, base word 1 is used.
  3. Otherwise, if the low size is zero, base word 0 is used.
  4. Otherwise, if the high size is zero, base word 1 is used.
- R2: When both sizes are nonzero and the address falls in neither region, the result is a fault at level 1 and no memory read is issued.
- R3: When the disable bit of the chosen region is set (control bit 7 for region 0, bit 23 for region 1), the result is a fault at level 1 and no memory read is issued.
- R4: With region size s, the walk starts as follows:
  - If s > 1, it starts at level 2 and clears base bits [13-s:0].
  - Otherwise it starts at level 1 and clears base bits [4-s:0].
  - The first descriptor address is the cleared base bits [39:0] ORed with bits [11:3] of (masked VA >> 9*(4-level)). The masked VA is the VA with its top s bits cleared.
- R5: A descriptor with bit 1 set at level 1 or 2 is a table entry. The next descriptor address is {descriptor[39:12], 12'h000} ORed with the index bits of the next level, and the level rises by one.
- R6: A descriptor with bit 0 clear gives a fault at the current level. So does a level-3 descriptor with bit 1 clear.
- R7: A level-1 or level-2 descriptor with bit 1 clear is a block; a valid level-3 descriptor with bit 1 set is a page. For either, the size is 2^(39-9*level) bytes (size exponent 30, 21 or 12). The physical address is {descriptor[39:12], 12'h000} ORed with the masked VA bits below the size.
- R8: The attribute vector is formed in these steps:
  1. Set attributes [9:0] to descriptor [11:2] and attributes [21:10] to descriptor [63:52].
  2. OR accumulated table bits [1:0] into attributes [12:11].
  3. OR accumulated table bit 3 into attribute 5.
  4. If accumulated table bit 2 is set, clear attribute 4.

  The accumulation is the OR of descriptor bits [63:59] over all table entries passed.
- R9: The memory port has at most one read outstanding. A request holds its valid and address stable until it is accepted. No read is issued while the walker is idle.
- R10: Completion is signalled by a `done` pulse of exactly one cycle. The result outputs change only with that pulse. A translation request is accepted only while the walker is idle, and any request offered while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tr_valid | input | 1 | Translation request valid |
| tr_ready | output | 1 | Walker idle, request can be taken |
| tr_ctrl | input | 32 | Translation control word |
| tr_base0 | input | 64 | Table base word for region 0 |
| tr_base1 | input | 64 | Table base word for region 1 |
| tr_vaddr | input | 32 | Virtual address to translate |
| rd_valid | output | 1 | Descriptor read request valid |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 40 | Descriptor address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 64 | Descriptor read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Result is a translation fault |
| res_level | output | 2 | Level where the walk ended |
| res_pa | output | 40 | Physical address |
| res_size_log2 | output | 6 | log2 of the mapped size in bytes |
| res_attr | output | 22 | Merged attribute vector |

## Verification
The bench builds the walker with its default widths: 32-bit virtual addresses, 40-bit physical addresses, 64-bit descriptors and 22 attribute bits. These defaults are the only widths at which the descriptor bit positions in the requirements hold. With them, every region-selection branch becomes reachable, along with both starting levels (region sizes 0, 1 and 2) and all three block or page sizes. The bench also drives a memory model that can hold back request acceptance every other cycle. This exercises the hold-until-accepted rule, and it keeps a walk busy long enough for a stray second request to arrive.

// File: rtl/ltw_walker.sv
module ltw_walker #(
  parameter int VA_W = 32,
  parameter int PA_W = 40,
  parameter int D_W  = 64,
  parameter int AT_W = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tr_valid,
  output logic            tr_ready,
  input  logic [31:0]     tr_ctrl,
  input  logic [D_W-1:0]  tr_base0,
  input  logic [D_W-1:0]  tr_base1,
  input  logic [VA_W-1:0] tr_vaddr,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [PA_W-1:0] rd_addr,
  input  logic            rsp_valid,
  input  logic [D_W-1:0]  rsp_data,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [1:0]      res_level,
  output logic [PA_W-1:0] res_pa,
  output logic [5:0]      res_size_log2,
  output logic [AT_W-1:0] res_attr
);
  localparam int PG_W = 12;
  localparam int TA_W = 5;
  localparam int ZX_W = PA_W - VA_W;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  function automatic logic [PA_W-1:0] idx_of(input logic [1:0] lv, input logic [VA_W-1:0] va);
    logic [VA_W-1:0] s;
    case (lv)
      2'd1:    s = va >> 27;
      2'd2:    s = va >> 18;
      default: s = va >> 9;
    endcase
    return {{(PA_W-PG_W){1'b0}}, s[11:3], 3'b000};
  endfunction

  st_t               st;
  logic [1:0]        lvl;
  logic [VA_W-1:0]   va_q;
  logic [PA_W-1:0]   daddr;
  logic [TA_W-1:0]   tattr;

  // region selection
  logic [2:0]      t0, t1, tsz;
  logic [VA_W-1:0] hm0, hm1, va_m;
  logic            in0, in1, sel1, gap, dis, start2;
  logic [3:0]      nsh;
  logic [D_W-1:0]  base;
  logic [PA_W-1:0] base_al, first_addr;

  assign t0   = tr_ctrl[2:0];
  assign t1   = tr_ctrl[18:16];
  assign hm0  = ~({VA_W{1'b1}} >> t0);
  assign hm1  = ~({VA_W{1'b1}} >> t1);
  assign in0  = (t0 != 3'd0) && ((tr_vaddr & hm0) == '0);
  assign in1  = (t1 != 3'd0) && ((~tr_vaddr & hm1) == '0);
  assign sel1 = !in0 && (in1 || ((t0 != 3'd0) && (t1 == 3'd0)));
  assign gap  = !in0 && !in1 && (t0 != 3'd0) && (t1 != 3'd0);
  assign tsz  = sel1 ? t1 : t0;
  assign dis  = sel1 ? tr_ctrl[23] : tr_ctrl[7];
  assign base = sel1 ? tr_base1 : tr_base0;
  assign start2 = tsz > 3'd1;
  assign nsh  = start2 ? (4'd14 - {1'b0, tsz}) : (4'd5 - {1'b0, tsz});
  assign base_al = base[PA_W-1:0] & ~((PA_W'(1) << nsh) - PA_W'(1));
  assign va_m = tr_vaddr & ({VA_W{1'b1}} >> tsz);
  assign first_addr = base_al | idx_of(start2 ? 2'd2 : 2'd1, va_m);

  // descriptor decode
  logic            d_bad, d_tbl;
  logic [5:0]      sl;
  logic [PA_W-1:0] d_out, off_m, blk_pa, nxt_addr;
  logic [AT_W-1:0] attr_c;
  logic [TA_W-1:0] tattr_n;

  assign d_bad = !rsp_data[0] || ((lvl == 2'd3) && !rsp_data[1]);
  assign d_tbl = rsp_data[1] && (lvl != 2'd3);
  assign d_out = {rsp_data[PA_W-1:PG_W], {PG_W{1'b0}}};
  assign sl    = (lvl == 2'd1) ? 6'd30 : (lvl == 2'd2) ? 6'd21 : 6'd12;
  assign off_m = (PA_W'(1) << sl) - PA_W'(1);
  assign blk_pa = d_out | ({{ZX_W{1'b0}}, va_q} & off_m);
  assign nxt_addr = d_out | idx_of(lvl + 2'd1, va_q);
  assign tattr_n = tattr | rsp_data[D_W-1:D_W-TA_W];

  always_comb begin
    attr_c = {rsp_data[63:52], rsp_data[11:2]};
    attr_c[12:11] = attr_c[12:11] | tattr[1:0];
    attr_c[5] = attr_c[5] | tattr[3];
    if (tattr[2]) attr_c[4] = 1'b0;
  end

  assign busy     = (st != S_IDLE);
  assign tr_ready = !busy;
  assign rd_valid = (st == S_REQ);
  assign rd_addr  = daddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lvl <= 2'd1;
      va_q <= '0;
      daddr <= '0;
      tattr <= '0;
      done <= 1'b0;
      fault <= 1'b0;
      res_level <= 2'd0;
      res_pa <= '0;
      res_size_log2 <= '0;
      res_attr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (tr_valid) begin
          if (gap || dis) begin
            done <= 1'b1;
            fault <= 1'b1;
            res_level <= 2'd1;
          end else begin
            st <= S_REQ;
            lvl <= start2 ? 2'd2 : 2'd1;
            va_q <= va_m;
            daddr <= first_addr;
            tattr <= '0;
          end
        end
        S_REQ: if (rd_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (d_bad) begin
            st <= S_IDLE;
            done <= 1'b1;
            fault <= 1'b1;
            res_level <= lvl;
          end else if (d_tbl) begin
            st <= S_REQ;
            lvl <= lvl + 2'd1;
            daddr <= nxt_addr;
            tattr <= tattr_n;
          end else begin
            st <= S_IDLE;
            done <= 1'b1;
            fault <= 1'b0;
            res_level <= lvl;
            res_pa <= blk_pa;
            res_size_log2 <= sl;
            res_attr <= attr_c;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_pa) && $stable(res_attr) && $stable(fault));
  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_level != 2'd0);
  // R7
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> (res_size_log2 == 6'd30) || (res_size_log2 == 6'd21) || (res_size_log2 == 6'd12));
endmodule

// File: tb/ltw_walker_tb.sv
`timescale 1ns/1ps
module ltw_walker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        tr_valid = 1'b0;
  logic        tr_ready;
  logic [31:0] tr_ctrl = '0;
  logic [63:0] tr_base0 = '0, tr_base1 = '0;
  logic [31:0] tr_vaddr = '0;
  logic        rd_valid, rd_ready;
  logic [39:0] rd_addr;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        busy, done, fault;
  logic [1:0]  res_level;
  logic [39:0] res_pa;
  logic [5:0]  res_size_log2;
  logic [21:0] res_attr;

  ltw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_ready(tr_ready),
    .tr_ctrl(tr_ctrl), .tr_base0(tr_base0), .tr_base1(tr_base1), .tr_vaddr(tr_vaddr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .done(done),
    .fault(fault), .res_level(res_level), .res_pa(res_pa),
    .res_size_log2(res_size_log2), .res_attr(res_attr)
  );

  int n_chk = 0, n_bad = 0;
  int nreads = 0;
  int ndone = 0;
  logic [39:0] last_rd = '0;
  bit stall = 1'b0;
  logic rdy_r = 1'b1;
  assign rd_ready = rdy_r;

  logic [39:0] ma [16];
  logic [63:0] md [16];
  int mn = 0;

  task automatic put(input logic [39:0] a, input logic [63:0] d);
    ma[mn] = a; md[mn] = d; mn++;
  endtask

  function automatic logic [63:0] lookup(input logic [39:0] a);
    for (int i = 0; i < mn; i++) if (ma[i] == a) return md[i];
    return 64'h0;
  endfunction

  always @(posedge clk) begin
    rdy_r <= stall ? ~rdy_r : 1'b1;
    rsp_valid <= 1'b0;
    if (done) ndone <= ndone + 1;
    if (rd_valid && rd_ready) begin
      rsp_valid <= 1'b1;
      rsp_data <= lookup(rd_addr);
      nreads <= nreads + 1;
      last_rd <= rd_addr;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] c, input logic [63:0] b0, input logic [63:0] b1,
                       input logic [31:0] va, input bit stl, input bit inj);
    int n;
    @(negedge clk);
    stall = stl; tr_ctrl = c; tr_base0 = b0; tr_base1 = b1; tr_vaddr = va;
    nreads = 0; ndone = 0; tr_valid = 1'b1;
    @(negedge clk);
    tr_valid = 1'b0;
    if (inj) begin
      chk("R10 busy while walking", {63'b0, busy}, 64'h1);
      tr_vaddr = ~va; tr_ctrl = 32'h0000_0082; tr_valid = 1'b1;
      @(negedge clk);
      tr_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 timeout: actual no done expected done");
    end
    @(negedge clk);
    chk("R10 done one cycle", {63'b0, done}, 64'h0);
    chk("R10 idle after done", {63'b0, busy}, 64'h0);
    stall = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset no read", {63'b0, rd_valid}, 64'h0);
    chk("R10 reset done low", {63'b0, done}, 64'h0);
    chk("R10 reset idle", {63'b0, tr_ready}, 64'h1);
  endtask

  // R1 R4 R5 R7 R8: level-2 start, table, then page
  task automatic t_page();
    logic [31:0] va = 32'h1234_5678;
    put(40'h12_3456_7000 | 40'((va >> 18) & 32'hff8), 64'h2000_0000_0ABC_D003);
    put(40'h00_0ABC_D000 | 40'((va >> 9) & 32'hff8), 64'h0040_0055_6677_8443);
    xlate(32'h2, 64'h0000_0012_3456_7ABC, 64'h0000_0099_0000_0000, va, 1'b0, 1'b0);
    chk("R4 R5 two reads", 64'(nreads), 64'd2);
    chk("R7 page fault flag", {63'b0, fault}, 64'h0);
    chk("R7 page level", {62'b0, res_level}, 64'd3);
    chk("R7 page pa", {24'b0, res_pa}, 64'h55_6677_8678);
    chk("R7 page size", {58'b0, res_size_log2}, 64'd12);
    chk("R8 attr AP clear XN", {42'b0, res_attr}, 64'h1100);
  endtask

  // R6: level-3 reserved encoding
  task automatic t_reserved();
    logic [31:0] va = 32'h1234_6000;
    put(40'h00_0ABC_D000 | 40'((va >> 9) & 32'hff8), 64'h0000_0011_1111_1001);
    xlate(32'h2, 64'h0000_0012_3456_7000, 64'h0, va, 1'b0, 1'b0);
    chk("R6 reserved fault", {63'b0, fault}, 64'h1);
    chk("R6 reserved level", {62'b0, res_level}, 64'd3);
  endtask

  // R1 base 1 by ones, R7 level-1 block, R9 stall, R10 injected request
  task automatic t_block1();
    put(40'h01_0000_0008, 64'h0000_0080_4000_0401);
    xlate(32'h0001_0001, 64'h0000_0002_0000_0000, 64'h0000_0001_0000_0007,
          32'hC000_1234, 1'b1, 1'b1);
    chk("R1 R10 one walk one done", 64'(ndone), 64'd1);
    chk("R1 base1 read addr", {24'b0, last_rd}, 64'h01_0000_0008);
    chk("R7 block1 fault", {63'b0, fault}, 64'h0);
    chk("R7 block1 level", {62'b0, res_level}, 64'd1);
    chk("R7 block1 pa", {24'b0, res_pa}, 64'h80_4000_1234);
    chk("R7 block1 size", {58'b0, res_size_log2}, 64'd30);
    chk("R8 block1 attr", {42'b0, res_attr}, 64'h100);
  endtask

  // R1 fallback to base 0, R6 invalid at level 1
  task automatic t_fallback();
    xlate(32'h0002_0000, 64'h0000_0000_0030_0000, 64'h0000_0000_0040_0000,
          32'h4000_0000, 1'b0, 1'b0);
    chk("R1 fallback base0 addr", {24'b0, last_rd}, 64'h30_0008);
    chk("R6 invalid reads", 64'(nreads), 64'd1);
    chk("R6 invalid fault", {63'b0, fault}, 64'h1);
    chk("R6 invalid level", {62'b0, res_level}, 64'd1);
  endtask

  task automatic t_gap();
    xlate(32'h0002_0002, 64'h0, 64'h0, 32'h4000_0000, 1'b0, 1'b0);
    chk("R2 gap fault", {63'b0, fault}, 64'h1);
    chk("R2 gap level", {62'b0, res_level}, 64'd1);
    chk("R2 gap no read", 64'(nreads), 64'd0);
  endtask

  task automatic t_disable();
    xlate(32'h0000_0082, 64'h0000_0000_0010_0000, 64'h0, 32'h1000_0000, 1'b0, 1'b0);
    chk("R3 disable0 fault", {63'b0, fault}, 64'h1);
    chk("R3 disable0 no read", 64'(nreads), 64'd0);
    xlate(32'h0081_0000, 64'h0000_0000_0010_0000, 64'h0000_0000_0020_0000,
          32'h8000_0000, 1'b0, 1'b0);
    chk("R3 disable1 fault", {63'b0, fault}, 64'h1);
    chk("R3 disable1 level", {62'b0, res_level}, 64'd1);
    chk("R3 disable1 no read", 64'(nreads), 64'd0);
  endtask

  // R5 R8: table attrs at level 1 then level-2 block
  task automatic t_block2();
    logic [31:0] va = 32'h8765_4321;
    logic [39:0] l2 = 40'h20_0000 | 40'((va >> 18) & 32'hff8);
    put(40'h10_0000 | 40'((va >> 27) & 32'hff8), 64'h5800_0000_0020_0003);
    put(l2, 64'h0000_0033_4400_0401);
    xlate(32'h0, 64'h0000_0000_0010_0000, 64'h0, va, 1'b1, 1'b0);
    chk("R5 second addr", {24'b0, last_rd}, {24'b0, l2});
    chk("R7 block2 level", {62'b0, res_level}, 64'd2);
    chk("R7 block2 size", {58'b0, res_size_log2}, 64'd21);
    chk("R7 block2 pa", {24'b0, res_pa}, {24'b0, 40'h33_4400_0000 | 40'(va & 32'h1F_FFFF)});
    chk("R8 table attrs", {42'b0, res_attr}, 64'h1920);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_page();
    t_reserved();
    t_block1();
    t_fallback();
    t_gap();
    t_disable();
    t_block2();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule